// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to a SECDED-protected 64-bit memory data path. The encoder and decoder are outside the block. The decoder reports each bad read as a single-cycle pulse, either correctable or uncorrectable, together with the failing address, the 8-bit syndrome and the 64-bit data word. Each error class has its own capture slot, which keeps the details of the first error of that class. While that first error is still pending, a later error of the same class sets only a "second error" flag. Any pending flag drives a level interrupt.

Software reads the interrupt status word. It then collects the logged address, syndrome and data, and writes the status word back to the acknowledge register, which clears bits where a one is written. An option register selects the ECC mode. It can also arm a one-shot corruption of the check bits: on the next memory write, the 8-bit check code from the encoder is XORed with a programmable mask, which plants a known error for testing.

The register bus is synchronous, with a read latency of one cycle. The capture window starts at byte 0x00. The interrupt window starts at byte `INT_BASE`, which is 0x40 by default.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the interrupt status word, every capture register and the option register read 0, and irq_o is low.
- R2: Option bits [1:0] hold the ECC mode. When bit 0 of the mode is 0 (mode 0 or 2), error pulses are ignored: no status bit changes and nothing is captured.
- R3: In mode 1 or 3, a correctable pulse on an idle slot sets status bit 3 and captures the event. The address reads at 0x18, the syndrome at 0x1C bits [15:8] with all other bits 0, data bits [31:0] at 0x20 and data bits [63:32] at 0x24.
- R4: An uncorrectable pulse on an idle slot sets status bit 5 and captures the event the same way. The address reads at 0x08, the syndrome at 0x0C bits [15:8], data low at 0x10 and data high at 0x14.
- R5: While a class's primary bit (3 or 5) is set, a further error of that class sets its second-error bit (4 or 6) and leaves the captured address, syndrome and data unchanged.
- R6: Writing to the acknowledge register at INT_BASE+0x04 clears each status bit written as 1 and leaves every other bit as it was. irq_o is high exactly while any status bit is set.
- R7: If an error pulse arrives in the same cycle as an acknowledge that clears that class's primary bit, the primary bit stays set, the new event is captured, and the second-error bit is not set.
- R8: The option register at 0x00 reads back the mode in [1:0], the arm bit in bit 8 and the injection mask in [23:16]. All other bits read 0.
- R9: While the arm bit is set, chk_o equals chk_i XOR the mask on the first cycle in which wr_req_i is high, and equals chk_i at all other times. The arm bit then clears by itself, and the mask keeps its value.
- R10: reg_rdata_o presents the register addressed in the previous cycle when reg_re_i was high, and is 0 otherwise. Unmapped offsets and the acknowledge register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_re_i | input | 1 | Read strobe |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| ce_i | input | 1 | Correctable error pulse |
| ue_i | input | 1 | Uncorrectable error pulse |
| err_addr_i | input | 32 | Address of the failing access |
| err_syn_i | input | 8 | Syndrome of the failing access |
| err_data_i | input | 64 | Data word of the failing access |
| wr_req_i | input | 1 | Memory write in this cycle |
| chk_i | input | 8 | Check bits from the encoder |
| chk_o | output | 8 | Check bits sent to memory |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit logged address, an 8-bit bus address and the interrupt window at 0x40. With these values, full-width random addresses and both 32-bit halves of each data word pass through the capture slots and can be compared against the bench's model. Because the interrupt window sits well clear of the capture window, the bench can read the gap offsets between them and check that they return zero.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int LOG_AW = 32;
  localparam int DATA_W = 64;
  localparam int SYN_W  = 8;
  localparam int CHK_W  = 8;
  localparam int BUS_AW = 8;
  localparam int N_CLS  = 2;  // 0: correctable, 1: uncorrectable

  localparam logic [BUS_AW-1:0] OFS_OPT   = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_UADDR = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_USTAT = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_UDL   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_UDH   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_CADDR = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_CSTAT = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_CDL   = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_CDH   = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_ISTAT = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_IACK  = 8'h04;

  // primary bit of class c is STAT_LSB + 2c, second-error bit is one above
  localparam int STAT_LSB = 3;

  typedef struct packed {
    logic [LOG_AW-1:0] addr;
    logic [SYN_W-1:0]  syn;
    logic [DATA_W-1:0] data;
  } err_rec_t;
endpackage

// File: rtl/ecc_log_slot.sv
module ecc_log_slot
  import ecc_log_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  logic     ack_pri_i,
  input  logic     ack_sec_i,
  input  err_rec_t rec_i,
  output logic     pri_o,
  output logic     sec_o,
  output err_rec_t rec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_o <= 1'b0;
      sec_o <= 1'b0;
      rec_o <= '0;
    end else begin
      // capture only into a free slot, or one being released this cycle
      if (hit_i && (!pri_o || ack_pri_i)) rec_o <= rec_i;
      if (hit_i)          pri_o <= 1'b1;
      else if (ack_pri_i) pri_o <= 1'b0;
      if (hit_i && pri_o && !ack_pri_i) sec_o <= 1'b1;
      else if (ack_sec_i)               sec_o <= 1'b0;
    end
  end

  // R5
  slot_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_o && !ack_pri_i) |=> $stable(rec_o));
  // R5
  second_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && pri_o && !ack_pri_i) |=> sec_o);
  // R7
  err_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pri_o);
  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_pri_i && !hit_i) |=> !pri_o);
endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl
  import ecc_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             opt_we_i,
  input  logic [31:0]      opt_wdata_i,
  input  logic             wr_req_i,
  input  logic [CHK_W-1:0] chk_i,
  output logic [CHK_W-1:0] chk_o,
  output logic [1:0]       mode_o,
  output logic [31:0]      opt_o
);
  logic             fwc_q;
  logic [CHK_W-1:0] mask_q;
  logic             unused_wdata;

  assign unused_wdata = ^{opt_wdata_i[31:24], opt_wdata_i[15:9], opt_wdata_i[7:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= 2'b00;
      fwc_q  <= 1'b0;
      mask_q <= '0;
    end else if (opt_we_i) begin
      mode_o <= opt_wdata_i[1:0];
      fwc_q  <= opt_wdata_i[8];
      mask_q <= opt_wdata_i[23:16];
    end else if (wr_req_i) begin
      fwc_q  <= 1'b0;
    end
  end

  assign chk_o = (fwc_q && wr_req_i) ? (chk_i ^ mask_q) : chk_i;
  assign opt_o = {8'h00, mask_q, 7'h00, fwc_q, 6'h00, mode_o};

  // R9
  fwc_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwc_q && wr_req_i && !opt_we_i) |=> !fwc_q);
  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt_we_i |=> $stable(mask_q));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter logic [BUS_AW-1:0] INT_BASE = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] reg_addr_i,
  input  logic              reg_re_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [LOG_AW-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic              wr_req_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              irq_o
);
  localparam logic [BUS_AW-1:0] ISTAT_A = INT_BASE + OFS_ISTAT;
  localparam logic [BUS_AW-1:0] IACK_A  = INT_BASE + OFS_IACK;

  logic [1:0]       mode;
  logic [31:0]      opt_word;
  logic             log_en;
  logic             ack_we;
  logic             opt_we;
  logic [N_CLS-1:0] err_v, hit, pri, sec, ack_pri, ack_sec;
  err_rec_t         rec_in;
  err_rec_t         rec [N_CLS];
  logic [31:0]      istat;
  logic [31:0]      rd_mux;

  assign log_en = mode[0];  // modes 0 and 2 disable logging
  assign ack_we = reg_we_i && (reg_addr_i == IACK_A);
  assign opt_we = reg_we_i && (reg_addr_i == OFS_OPT);
  assign err_v  = {ue_i, ce_i};
  assign rec_in = '{addr: err_addr_i, syn: err_syn_i, data: err_data_i};

  ecc_inject_ctl u_inj (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .opt_we_i    (opt_we),
    .opt_wdata_i (reg_wdata_i),
    .wr_req_i    (wr_req_i),
    .chk_i       (chk_i),
    .chk_o       (chk_o),
    .mode_o      (mode),
    .opt_o       (opt_word)
  );

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    assign hit[c]     = err_v[c] & log_en;
    assign ack_pri[c] = ack_we & reg_wdata_i[STAT_LSB + 2*c];
    assign ack_sec[c] = ack_we & reg_wdata_i[STAT_LSB + 2*c + 1];

    ecc_log_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit[c]),
      .ack_pri_i (ack_pri[c]),
      .ack_sec_i (ack_sec[c]),
      .rec_i     (rec_in),
      .pri_o     (pri[c]),
      .sec_o     (sec[c]),
      .rec_o     (rec[c])
    );
  end

  always_comb begin
    istat = '0;
    for (int c = 0; c < N_CLS; c++) begin
      istat[STAT_LSB + 2*c]     = pri[c];
      istat[STAT_LSB + 2*c + 1] = sec[c];
    end
  end

  assign irq_o = |istat;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      OFS_OPT:   rd_mux = opt_word;
      OFS_UADDR: rd_mux = 32'(rec[1].addr);
      OFS_USTAT: rd_mux = {16'h0, rec[1].syn, 8'h0};
      OFS_UDL:   rd_mux = rec[1].data[31:0];
      OFS_UDH:   rd_mux = rec[1].data[63:32];
      OFS_CADDR: rd_mux = 32'(rec[0].addr);
      OFS_CSTAT: rd_mux = {16'h0, rec[0].syn, 8'h0};
      OFS_CDL:   rd_mux = rec[0].data[31:0];
      OFS_CDH:   rd_mux = rec[0].data[63:32];
      ISTAT_A:   rd_mux = istat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= reg_re_i ? rd_mux : 32'h0;
  end

  // R2
  no_log_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!log_en && !ack_we) |=> $stable(istat));
  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> (reg_rdata_o == 32'h0));
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ce = 1'b0, ue = 1'b0;
  logic [31:0] eaddr = '0;
  logic [7:0]  esyn = '0;
  logic [63:0] edata = '0;
  logic        wr_req = 1'b0;
  logic [7:0]  chk_in = '0;
  logic [7:0]  chk_out;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic        m_pri [2];
  logic        m_sec [2];
  logic [31:0] m_addr [2];
  logic [7:0]  m_syn [2];
  logic [63:0] m_data [2];
  logic [1:0]  m_mode = 2'b00;

  localparam logic [7:0] ISTAT = 8'h40;
  localparam logic [7:0] IACK  = 8'h44;

  always #4 clk = ~clk;

  ecc_err_log u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_re_i(re), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ce_i(ce), .ue_i(ue),
    .err_addr_i(eaddr), .err_syn_i(esyn), .err_data_i(edata), .wr_req_i(wr_req),
    .chk_i(chk_in), .chk_o(chk_out), .irq_o(irq)
  );

  function automatic logic [31:0] exp_stat();
    return {25'h0, m_sec[1], m_pri[1], m_sec[0], m_pri[0], 3'b000};
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    re = 1'b0; we = 1'b0; ce = 1'b0; ue = 1'b0; wr_req = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); idle(); addr = a; re = 1'b1;
    @(posedge clk); #1 d = rdata;
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); idle(); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic model_err(input int c, input logic [31:0] a, input logic [7:0] s, input logic [63:0] dd);
    if (m_mode[0]) begin
      if (!m_pri[c]) begin
        m_pri[c] = 1'b1; m_addr[c] = a; m_syn[c] = s; m_data[c] = dd;
      end else m_sec[c] = 1'b1;
    end
  endtask

  task automatic model_ack(input logic [31:0] m);
    for (int c = 0; c < 2; c++) begin
      if (m[3 + 2*c]) m_pri[c] = 1'b0;
      if (m[4 + 2*c]) m_sec[c] = 1'b0;
    end
  endtask

  task automatic err(input int c, input logic [31:0] a, input logic [7:0] s, input logic [63:0] dd);
    @(negedge clk); idle();
    eaddr = a; esyn = s; edata = dd;
    if (c == 0) ce = 1'b1; else ue = 1'b1;
    @(negedge clk); idle();
    model_err(c, a, s, dd);
  endtask

  task automatic ack(input logic [31:0] m);
    wr(IACK, m);
    model_ack(m);
  endtask

  task automatic set_mode(input logic [1:0] md);
    wr(8'h00, {30'h0, md});
    m_mode = md;
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] d;
    rd(ISTAT, d);
    chk(d, exp_stat(), tag);
    chk({31'h0, irq}, {31'h0, |exp_stat()}, tag);
  endtask

  task automatic chk_slot(input int c, input string tag);
    logic [31:0] d;
    logic [7:0]  b = (c == 0) ? 8'h18 : 8'h08;
    rd(b, d);          chk(d, m_addr[c], tag);
    rd(b + 8'h04, d);  chk(d, {16'h0, m_syn[c], 8'h0}, tag);
    rd(b + 8'h08, d);  chk(d, m_data[c][31:0], tag);
    rd(b + 8'h0C, d);  chk(d, m_data[c][63:32], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      m_pri[c] = 0; m_sec[c] = 0; m_addr[c] = 0; m_syn[c] = 0; m_data[c] = 0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk({31'h0, irq}, 32'h0, "R1 irq");
    chk_stat("R1 istat");
    rd(8'h00, d); chk(d, 32'h0, "R1 opt");
    chk_slot(0, "R1 ce slot");
    chk_slot(1, "R1 ue slot");

    // R2 disabled modes
    err(0, 32'h1111_2222, 8'h33, 64'h1);
    chk_stat("R2 mode0");
    set_mode(2'd2);
    err(1, 32'h4444_5555, 8'h66, 64'h2);
    chk_stat("R2 mode2");
    chk_slot(1, "R2 no capture");

    // R3 correctable capture
    set_mode(2'd1);
    err(0, 32'hDEAD_BEE8, 8'h5A, 64'h0123_4567_89AB_CDEF);
    chk_stat("R3 istat");
    chk_slot(0, "R3 fields");

    // R5 second correctable
    err(0, 32'h0BAD_F00D, 8'hC3, 64'hFFFF_0000_FFFF_0000);
    chk_stat("R5 ce second");
    chk_slot(0, "R5 ce frozen");

    // R4 uncorrectable capture, then R5 second
    err(1, 32'hCAFE_0010, 8'h81, 64'hA5A5_5A5A_1234_8765);
    chk_stat("R4 istat");
    chk_slot(1, "R4 fields");
    err(1, 32'h0000_0040, 8'h7E, 64'h0);
    chk_stat("R5 ue second");
    chk_slot(1, "R5 ue frozen");

    // R6 write-one-to-clear
    ack(32'h0000_0008);
    chk_stat("R6 partial ack");
    ack(32'hFFFF_FF87);  // no status bits set: no effect
    chk_stat("R6 zero bits");
    ack(32'h0000_0070);
    chk_stat("R6 full ack");

    // R7 error and ack in one cycle
    err(0, 32'h0000_1000, 8'h11, 64'h11);
    @(negedge clk); idle();
    addr = IACK; wdata = 32'h8; we = 1'b1;
    ce = 1'b1; eaddr = 32'h0000_2000; esyn = 8'h22; edata = 64'h22;
    @(negedge clk); idle();
    m_pri[0] = 1'b1; m_addr[0] = 32'h0000_2000; m_syn[0] = 8'h22; m_data[0] = 64'h22;
    chk_stat("R7 istat");
    chk_slot(0, "R7 capture");
    ack(32'h78);
    chk_stat("R7 cleanup");

    // R8 option readback
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk(d, 32'h00FF_0103, "R8 all ones");
    wr(8'h00, 32'h00A5_0101);
    rd(8'h00, d); chk(d, 32'h00A5_0101, "R8 value");

    // R9 injection: armed, idle cycles do not consume it
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); idle(); chk_in = 8'h3C; #1;
      chk({24'h0, chk_out}, 32'h3C, "R9 no write");
    end
    @(negedge clk); idle(); wr_req = 1'b1; chk_in = 8'h3C; #1;
    chk({24'h0, chk_out}, 32'h99, "R9 first write");
    @(negedge clk); idle(); wr_req = 1'b1; chk_in = 8'h3C; #1;
    chk({24'h0, chk_out}, 32'h3C, "R9 second write");
    @(negedge clk); idle();
    rd(8'h00, d); chk(d, 32'h00A5_0001, "R9 self clear");

    // R10 unmapped and idle reads
    rd(8'h04, d); chk(d, 32'h0, "R10 gap 04");
    rd(8'h30, d); chk(d, 32'h0, "R10 gap 30");
    rd(IACK, d);  chk(d, 32'h0, "R10 ack reads 0");
    @(negedge clk); idle(); addr = 8'h00;
    @(posedge clk); #1 chk(rdata, 32'h0, "R10 no strobe");

    // random mix
    m_mode = 2'd1;
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3)      err(0, $urandom, 8'($urandom), {$urandom, $urandom});
      else if (op < 6) err(1, $urandom, 8'($urandom), {$urandom, $urandom});
      else if (op < 9) ack({25'h0, 4'($urandom), 3'b000});
      else             set_mode(2'($urandom));
      chk_stat("R5 random istat");
      if (op < 6) chk_slot(op < 3 ? 0 : 1, "R3 random slot");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule